// File: doc/BRIEF.md
# Message-Signaled Interrupt Write Generator

This block sits at the outbound edge of a device and turns interrupt events from many internal sources into posted memory writes. Each write carries one shared message address and a data word that tells the host which interrupt vector fired. The data word has no other content. Software programs a small register set: a global enable, the number of allocated vectors (a power of two from 1 to 32), a 32-bit message address with an optional upper half, a 16-bit base data value and optional per-vector mask bits.

Source indices fold onto the allocated vectors. Events that cannot be sent yet are held as one pending bit per vector. Pending vectors are served in round-robin order, and only one write is outstanding on the valid/ready output at a time. No message leaves while any earlier DMA write accepted by the device is still waiting to leave the outbound port, so an interrupt never overtakes data it reports.

Top module: `msi_msg_gen`

## Requirements
- R1: After reset, msg_valid is 0, msg_addr and msg_data are 0, and all configuration, mask and pending state is clear.
- R2: Control register (cfg_sel=0) bit 0 is the enable, bits 3:1 are the vector-count code c (count = 2^c) and bit 4 is the 64-bit address enable. A code of 6 or 7 is not stored, and the earlier code stays in force; the other bits are still written.
- R3: Every message carries the address {upper half (cfg_sel=2), lower half (cfg_sel=1)}. When the 64-bit enable is 0, bits 63:32 of msg_addr are 0.
- R4: The message for vector k carries the base data (cfg_sel=3, bits 15:0) with its low c bits replaced by k.
- R5: Source s raises vector s mod 2^c, which means its index bits above bit c-1 are dropped.
- R6: When mask bit k (cfg_sel=4) is set, vector k sends no write and its events stay pending. Clearing the mask while the vector is pending sends exactly one write and clears the pending bit.
- R7: While the enable is 0, no message is started, and events are held as pending.
- R8: A message starts only when every DMA write counted on dma_accept has been matched by a dma_depart. An accept in the same cycle as the start counts as later.
- R9: Pending vectors are granted in round-robin order, starting from the vector after the last one granted. Each handshake (msg_valid and msg_ready both high) ends exactly one message.
- R10: While msg_valid is high and msg_ready is low, msg_valid, msg_addr and msg_data stay stable.
- R11: Several events on a vector that is already pending produce a single write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 control, 1 address low, 2 address high, 3 data, 4 mask |
| cfg_wdata | input | 32 | Register write data |
| irq_req | input | NSRC | One-cycle event pulses, one bit per source |
| dma_accept | input | 1 | A DMA write was accepted into the outbound path |
| dma_depart | input | 1 | An earlier accepted DMA write left the outbound port |
| msg_ready | input | 1 | Downstream accepts the message write |
| msg_valid | output | 1 | A message write is offered |
| msg_addr | output | 64 | Message address |
| msg_data | output | 16 | Message data (vector-selecting value) |

## Verification
The bound assertions check on every cycle the properties that can be stated locally. The count code never holds an illegal value. A message never starts while the checker's own count of outstanding DMA writes is non-zero, or while its vector is masked, or while the block is disabled. The upper address is zero when 64-bit addressing is off. The output holds steady under back-pressure, and it drops after each handshake. Other behaviour is shown only by the bench scenarios, which compare each write against a predicted queue: the exact data values for several base and count settings, folding of high source indices, the order in which a group of simultaneous events drains, merging of repeated events, rejection of an illegal count code, and the single write released on unmask.

// File: rtl/msi_pkg.sv
package msi_pkg;

    localparam int VEC_MAX = 32;
    localparam int VEC_W = $clog2(VEC_MAX);
    localparam int CODE_W = 3;
    localparam logic [CODE_W-1:0] CODE_MAX = CODE_W'(VEC_W);
    localparam int DATA_W = 16;
    localparam int HALF_W = 32;

    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_ALO  = 3'd1,
        SEL_AHI  = 3'd2,
        SEL_DATA = 3'd3,
        SEL_MASK = 3'd4
    } cfg_sel_e;

    typedef struct packed {
        logic              en;
        logic              a64;
        logic [CODE_W-1:0] code;
        logic [HALF_W-1:0] addr_lo;
        logic [HALF_W-1:0] addr_hi;
        logic [DATA_W-1:0] base;
    } cfg_t;

    typedef struct packed {
        logic [2*HALF_W-1:0] addr;
        logic [DATA_W-1:0]   data;
        logic [VEC_W-1:0]    vec;
    } msg_t;

    // low-bit mask covering the allocated vector index
    function automatic logic [VEC_W-1:0] vec_bits(input logic [CODE_W-1:0] code);
        logic [VEC_W:0] one_hot;
        one_hot = (VEC_W+1)'(1) << code;
        return VEC_W'(one_hot - 1'b1);
    endfunction

    function automatic logic [VEC_W-1:0] fold_src(input logic [VEC_W-1:0] src_lo,
                                                  input logic [CODE_W-1:0] code);
        return src_lo & vec_bits(code);
    endfunction

    function automatic logic [DATA_W-1:0] mk_data(input logic [DATA_W-1:0] base,
                                                  input logic [CODE_W-1:0] code,
                                                  input logic [VEC_W-1:0] vec);
        logic [DATA_W-1:0] m;
        m = {{(DATA_W-VEC_W){1'b0}}, vec_bits(code)};
        return (base & ~m) | ({{(DATA_W-VEC_W){1'b0}}, vec} & m);
    endfunction

endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
    import msi_pkg::*;
#(
    parameter bit ADDR64_CAP = 1'b1,
    parameter bit MASK_CAP   = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [2:0]         sel,
    input  logic [31:0]        wdata,
    output cfg_t               cfg,
    output logic [VEC_MAX-1:0] vmask
);

    cfg_t               cfg_q;
    logic [VEC_MAX-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            mask_q <= '0;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                SEL_CTRL: begin
                    cfg_q.en  <= wdata[0];
                    cfg_q.a64 <= wdata[4];
                    if (wdata[3:1] <= CODE_MAX)
                        cfg_q.code <= wdata[3:1];
                end
                SEL_ALO:  cfg_q.addr_lo <= wdata;
                SEL_AHI:  cfg_q.addr_hi <= wdata;
                SEL_DATA: cfg_q.base    <= wdata[DATA_W-1:0];
                SEL_MASK: mask_q        <= wdata[VEC_MAX-1:0];
                default: ;
            endcase
        end
    end

    generate
        if (ADDR64_CAP) begin : g_a64
            assign cfg = cfg_q;
        end else begin : g_a32
            always_comb begin
                cfg         = cfg_q;
                cfg.a64     = 1'b0;
                cfg.addr_hi = '0;
            end
        end
        if (MASK_CAP) begin : g_mask
            assign vmask = mask_q;
        end else begin : g_nomask
            assign vmask = '0;
        end
    endgenerate

endmodule

// File: rtl/msi_pend_track.sv
module msi_pend_track
    import msi_pkg::*;
#(
    parameter int NSRC = 40
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NSRC-1:0]    irq,
    input  logic [CODE_W-1:0]  code,
    input  logic               clr,
    input  logic [VEC_W-1:0]   clr_vec,
    output logic [VEC_MAX-1:0] pend
);

    logic [VEC_MAX-1:0] set_v;
    logic [VEC_MAX-1:0] clr_v;

    always_comb begin
        set_v = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (irq[s])
                set_v[fold_src(VEC_W'(s), code)] = 1'b1;
        end
        clr_v = clr ? (VEC_MAX'(1) << clr_vec) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr_v) | set_v;
    end

endmodule

// File: rtl/msi_rr_arb.sv
module msi_rr_arb
    import msi_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [VEC_MAX-1:0] req,
    input  logic               adv,
    output logic               gnt_ok,
    output logic [VEC_W-1:0]   gnt_vec
);

    logic [VEC_W-1:0] ptr;
    logic [VEC_W-1:0] idx;

    always_comb begin
        gnt_ok  = 1'b0;
        gnt_vec = '0;
        idx     = '0;
        for (int i = 0; i < VEC_MAX; i++) begin
            idx = ptr + VEC_W'(i);
            if (!gnt_ok && req[idx]) begin
                gnt_ok  = 1'b1;
                gnt_vec = idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      ptr <= '0;
        else if (adv) ptr <= gnt_vec + 1'b1;
    end

endmodule

// File: rtl/msi_order_ctr.sv
module msi_order_ctr #(
    parameter int CW = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic depart,
    output logic clear
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else if (accept && !depart) cnt <= cnt + 1'b1;
        else if (depart && !accept) cnt <= cnt - 1'b1;
    end

    assign clear = (cnt == '0);

endmodule

// File: rtl/msi_msg_gen.sv
module msi_msg_gen
    import msi_pkg::*;
#(
    parameter int NSRC       = 40,
    parameter int DMA_CW     = 8,
    parameter bit ADDR64_CAP = 1'b1,
    parameter bit MASK_CAP   = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_sel,
    input  logic [31:0]     cfg_wdata,
    input  logic [NSRC-1:0] irq_req,
    input  logic            dma_accept,
    input  logic            dma_depart,
    input  logic            msg_ready,
    output logic            msg_valid,
    output logic [63:0]     msg_addr,
    output logic [15:0]     msg_data
);

    cfg_t               cfg;
    logic [VEC_MAX-1:0] mask_q;
    logic [VEC_MAX-1:0] pend;
    logic [VEC_MAX-1:0] eligible;
    logic               gnt_ok;
    logic [VEC_W-1:0]   gnt_vec;
    logic               dma_clear;
    logic               issue;
    logic               valid_q;
    msg_t               msg_q;

    // observation points for the bound checker
    logic               ctl_en;
    logic               ctl_a64;
    logic [CODE_W-1:0]  ctl_code;
    logic [VEC_W-1:0]   cur_vec;

    msi_cfg_regs #(.ADDR64_CAP(ADDR64_CAP), .MASK_CAP(MASK_CAP)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .cfg(cfg), .vmask(mask_q)
    );

    msi_pend_track #(.NSRC(NSRC)) u_pend (
        .clk(clk), .rst(rst), .irq(irq_req), .code(cfg.code),
        .clr(issue), .clr_vec(gnt_vec), .pend(pend)
    );

    assign eligible = cfg.en ? (pend & ~mask_q) : '0;

    msi_rr_arb u_arb (
        .clk(clk), .rst(rst), .req(eligible), .adv(issue),
        .gnt_ok(gnt_ok), .gnt_vec(gnt_vec)
    );

    msi_order_ctr #(.CW(DMA_CW)) u_order (
        .clk(clk), .rst(rst), .accept(dma_accept), .depart(dma_depart),
        .clear(dma_clear)
    );

    assign issue = !valid_q && gnt_ok && dma_clear;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            msg_q   <= '0;
        end else if (issue) begin
            valid_q    <= 1'b1;
            msg_q.addr <= {cfg.a64 ? cfg.addr_hi : {HALF_W{1'b0}}, cfg.addr_lo};
            msg_q.data <= mk_data(cfg.base, cfg.code, gnt_vec);
            msg_q.vec  <= gnt_vec;
        end else if (valid_q && msg_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign msg_valid = valid_q;
    assign msg_addr  = msg_q.addr;
    assign msg_data  = msg_q.data;

    assign ctl_en   = cfg.en;
    assign ctl_a64  = cfg.a64;
    assign ctl_code = cfg.code;
    assign cur_vec  = msg_q.vec;

endmodule

// File: rtl/msi_msg_chk.sv
module msi_msg_chk (
    input logic        clk,
    input logic        rst,
    input logic        dma_accept,
    input logic        dma_depart,
    input logic        msg_valid,
    input logic        msg_ready,
    input logic [63:0] msg_addr,
    input logic [15:0] msg_data,
    input logic        ctl_en,
    input logic        ctl_a64,
    input logic [2:0]  ctl_code,
    input logic [31:0] vec_mask,
    input logic [4:0]  cur_vec
);

    logic [15:0] dma_out;

    always_ff @(posedge clk) begin
        if (rst) dma_out <= '0;
        else if (dma_accept && !dma_depart) dma_out <= dma_out + 1'b1;
        else if (dma_depart && !dma_accept) dma_out <= dma_out - 1'b1;
    end

    // R2
    code_legal_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_code <= 3'd5);

    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid) && !$past(ctl_a64) |-> msg_addr[63:32] == 32'h0);

    // R6
    masked_silent_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid) |-> ($past(vec_mask) & (32'h1 << cur_vec)) == 32'h0);

    // R7
    disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_en && !msg_valid |=> !msg_valid);

    // R8
    dma_order_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid) |-> $past(dma_out) == 16'h0);

    // R9
    one_per_hs_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_ready |=> !msg_valid);

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

endmodule

bind msi_msg_gen msi_msg_chk i_chk (
    .clk(clk), .rst(rst), .dma_accept(dma_accept), .dma_depart(dma_depart),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data), .ctl_en(ctl_en), .ctl_a64(ctl_a64),
    .ctl_code(ctl_code), .vec_mask(mask_q), .cur_vec(cur_vec)
);

// File: tb/test_msi_msg_gen.sv
module test_msi_msg_gen;

    localparam int NSRC = 40;
    localparam logic [63:0] A64 = 64'h0000_0001_FEE0_1000;
    localparam logic [63:0] A32 = 64'h0000_0000_FEE0_1000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_we = 1'b0;
    logic [2:0]      cfg_sel = '0;
    logic [31:0]     cfg_wdata = '0;
    logic [NSRC-1:0] irq_req = '0;
    logic            dma_accept = 1'b0;
    logic            dma_depart = 1'b0;
    logic            msg_ready = 1'b1;
    logic            msg_valid;
    logic [63:0]     msg_addr;
    logic [15:0]     msg_data;

    msi_msg_gen #(.NSRC(NSRC)) i_msi_msg_gen (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .irq_req(irq_req), .dma_accept(dma_accept),
        .dma_depart(dma_depart), .msg_ready(msg_ready), .msg_valid(msg_valid),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [63:0] a;
        logic [15:0] d;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_err = 0;
    int   hs_cnt = 0;
    int   bptr = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] bdata(input logic [15:0] base, input int code, input int v);
        int m;
        m = (1 << code) - 1;
        return (base & ~16'(m)) | 16'(v & m);
    endfunction

    task automatic push(input int v, input logic [63:0] a, input logic [15:0] d, input string tag);
        exp_t e;
        e.a = a; e.d = d; e.tag = tag;
        q.push_back(e);
        bptr = (v + 1) % 32;
    endtask

    task automatic exp_group(input logic [31:0] vs, input logic [63:0] a,
                             input logic [15:0] base, input int code, input string tag);
        int start;
        start = bptr;
        for (int i = 0; i < 32; i++) begin
            int v;
            v = (start + i) % 32;
            if (vs[v]) push(v, a, bdata(base, code, v), tag);
        end
    endtask

    // monitor: pops expected items on every handshake
    always @(negedge clk) begin
        if (!rst && msg_valid && msg_ready) begin
            hs_cnt++;
            if (q.size() == 0) begin
                chk(1'b0, "unexpected write", {msg_addr[47:0], msg_data}, 64'h0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(msg_addr == e.a, {e.tag, " addr"}, msg_addr, e.a);
                chk(msg_data == e.d, {e.tag, " data"}, 64'(msg_data), 64'(e.d));
            end
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic fire(input logic [NSRC-1:0] bits);
        @(negedge clk);
        irq_req = bits;
        @(negedge clk);
        irq_req = '0;
    endtask

    task automatic pulse_dma(input bit acc);
        @(negedge clk);
        if (acc) dma_accept = 1'b1; else dma_depart = 1'b1;
        @(negedge clk);
        dma_accept = 1'b0; dma_depart = 1'b0;
    endtask

    task automatic drain(input string tag);
        int t;
        t = 0;
        while ((q.size() != 0 || msg_valid) && t < 300) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        chk(q.size() == 0, {tag, " drained"}, 64'(q.size()), 64'h0);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(msg_valid == 1'b0, "R1 valid", 64'(msg_valid), 64'h0);
        chk(msg_addr == 64'h0 && msg_data == 16'h0, "R1 outputs", msg_addr, 64'h0);

        // R7: disabled, events pend
        wr(3'd1, 32'hFEE0_1000);
        wr(3'd2, 32'h0000_0001);
        wr(3'd3, 32'h0000_4A20);
        wr(3'd0, 32'h16);             // 8 vectors, 64-bit on, enable off
        fire((NSRC)'(1) << 2 | (NSRC)'(1) << 5);
        repeat (8) @(negedge clk);
        chk(hs_cnt == 0 && !msg_valid, "R7 no write while disabled", 64'(hs_cnt), 64'h0);
        exp_group(32'h24, A64, 16'h4A20, 3, "R7");
        wr(3'd0, 32'h17);
        drain("R7");
        chk(hs_cnt == 2, "R7 pending released", 64'(hs_cnt), 64'd2);

        // R5 folding of high sources
        push(5, A64, 16'h4A25, "R5 src13");
        fire((NSRC)'(1) << 13);
        drain("R5");
        push(7, A64, 16'h4A27, "R5 src39");
        fire((NSRC)'(1) << 39);
        drain("R5");

        // R9 round-robin groups
        exp_group(32'h4A, A64, 16'h4A20, 3, "R9 group1");
        fire((NSRC)'(1) << 1 | (NSRC)'(1) << 3 | (NSRC)'(1) << 6);
        drain("R9");
        exp_group(32'hC2, A64, 16'h4A20, 3, "R9 group2");
        fire((NSRC)'(1) << 1 | (NSRC)'(1) << 6 | (NSRC)'(1) << 7);
        drain("R9");

        // R4 base with low bits set, 4 vectors
        wr(3'd3, 32'h0000_4A27);
        wr(3'd0, 32'h15);
        push(2, A64, 16'h4A26, "R4 vec2");
        fire((NSRC)'(1) << 6);
        drain("R4");
        push(1, A64, 16'h4A25, "R4 vec1");
        fire((NSRC)'(1) << 1);
        drain("R4");

        // R6 and R11: masked vector, repeated events
        wr(3'd4, 32'h8);
        h0 = hs_cnt;
        fire((NSRC)'(1) << 3);
        fire((NSRC)'(1) << 3);
        fire((NSRC)'(1) << 7);
        repeat (8) @(negedge clk);
        chk(hs_cnt == h0 && !msg_valid, "R6 masked silent", 64'(hs_cnt - h0), 64'h0);
        push(3, A64, 16'h4A27, "R6 unmask");
        wr(3'd4, 32'h0);
        drain("R6");
        chk(hs_cnt == h0 + 1, "R11 single write after merge", 64'(hs_cnt - h0), 64'd1);

        // R3: 64-bit addressing off
        wr(3'd0, 32'h05);
        push(0, A32, 16'h4A24, "R3 upper zero");
        fire((NSRC)'(1) << 0);
        drain("R3");

        // R2: illegal code 6 leaves 4-vector count in place
        wr(3'd0, 32'h1D);
        push(2, A64, 16'h4A26, "R2 illegal code kept");
        fire((NSRC)'(1) << 6);
        drain("R2");

        // R8: ordering behind DMA writes
        pulse_dma(1'b1); pulse_dma(1'b1); pulse_dma(1'b1);
        h0 = hs_cnt;
        fire((NSRC)'(1) << 1);
        repeat (10) @(negedge clk);
        chk(hs_cnt == h0 && !msg_valid, "R8 held behind 3 DMA", 64'(hs_cnt - h0), 64'h0);
        pulse_dma(1'b0); pulse_dma(1'b0);
        repeat (5) @(negedge clk);
        chk(hs_cnt == h0 && !msg_valid, "R8 held behind 1 DMA", 64'(hs_cnt - h0), 64'h0);
        push(1, A64, 16'h4A25, "R8 released");
        pulse_dma(1'b0);
        drain("R8");
        chk(hs_cnt == h0 + 1, "R8 one write", 64'(hs_cnt - h0), 64'd1);

        // R10: back-pressure
        @(negedge clk);
        msg_ready = 1'b0;
        fire((NSRC)'(1) << 2);
        repeat (6) @(negedge clk);
        chk(msg_valid == 1'b1, "R10 valid held", 64'(msg_valid), 64'h1);
        chk(msg_data == 16'h4A26, "R10 data held", 64'(msg_data), 64'h4A26);
        push(2, A64, 16'h4A26, "R10 after stall");
        msg_ready = 1'b1;
        drain("R10");

        finish_run();
    end

endmodule